// File: doc/BRIEF.md
# Cumulative Top-of-Bank Memory Decoder

This block maps a physical byte address onto one of a set of DRAM banks. Every bank has a 16-bit configuration word. The word holds a cumulative upper limit in 32 MB units, and that limit covers the bank itself plus every lower-numbered bank. The word also holds a flag that marks the bank as fitted, a flag for banks with only one row, and a flag that picks 4:1 or 2:1 interleave. A bank that is not fitted repeats the limit of the bank below it, so its size is zero.

The decode is combinational from the address and the stored configuration, and its result is registered once. The result is a one-hot bank select, a row select inside the chosen bank, the interleave mode of that bank, and a miss flag for addresses above all installed memory. A per-bank refresh-enable vector follows the fitted flags directly. Software writes the configuration words through a simple port with byte enables and reads them back by index.

Top module: `tob_bank_decoder`

## Requirements
- R1: Each configuration word has this layout: bit 15 is interleave (1 = 4:1, 0 = 2:1), bit 14 is single-row, bit 13 is fitted, bits 12:10 are reserved, and bits 9:0 are the limit. After reset every word reads 16'hA200.
- R2: A write with `cfg_be[0]` set loads word bits 7:0. A write with `cfg_be[1]` set loads bits 15:13 and 9:8. Writes to bits 12:10 are ignored, and those bits always read as zero on `cfg_rdata`.
- R3: `bank_sel` selects the lowest-numbered bank whose limit times 32 MB is strictly greater than the address. At most one bit of `bank_sel` is high.
- R4: A bank whose limit equals the limit of the bank below it is never selected. Bank 0's lower bound is address zero.
- R5: When no bank's limit exceeds the address, `miss` is 1 and `bank_sel`, `row_sel` and `mode_4to1` are all 0. Whenever `bank_sel` is non-zero, `miss` is 0.
- R6: For a selected bank with the single-row bit clear, `row_sel` is 1 when the address is at or above the middle of the bank's range. That middle is (lower limit + upper limit) × 16 MB. For a single-row bank, `row_sel` is 0.
- R7: `mode_4to1` equals the interleave bit of the selected bank.
- R8: `refresh_en[i]` equals the fitted bit of bank i and is low whenever that bit is clear, whatever the decode result.
- R9: `bank_sel`, `row_sel`, `mode_4to1` and `miss` reflect the address and the configuration of the previous clock cycle: one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_widx | input | IDX_W | Index of the bank word being written |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_raddr | input | IDX_W | Index of the bank word to read |
| cfg_rdata | output | 16 | Read data, reserved bits zero |
| addr_in | input | ADDR_W | Physical byte address to decode |
| bank_sel | output | NB | One-hot selected bank, registered |
| row_sel | output | 1 | Row within the selected bank, registered |
| mode_4to1 | output | 1 | Interleave mode of the selected bank, registered |
| miss | output | 1 | Address lies above all installed memory, registered |
| refresh_en | output | NB | Per-bank refresh enable |

## Verification
On every cycle the assertions check these properties:
- `bank_sel` is at most one-hot.
- `miss` agrees with an empty select, and a miss forces row and mode to zero.
- The reserved read bits are zero.
- Each refresh enable matches the fitted bit read back for that bank.
- The outputs hold steady when the address and the configuration hold steady.

Only the bench scenarios can show that the right bank is chosen. They do this with a layout that contains zero-size banks, by probing each limit one byte and one 32 MB unit on either side, and by probing the two-row midpoints and the region above memory. The bench scenarios also show the byte-enable merge, the reset contents and the priority between overlapping limits.

// File: rtl/tob_pkg.sv
package tob_pkg;
  localparam int LIM_W = 10;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic             il4;
    logic             single;
    logic             fitted;
    logic [LIM_W-1:0] lim;
  } bank_cfg_t;

  localparam bank_cfg_t CFG_RST = '{il4: 1'b1, single: 1'b0, fitted: 1'b1, lim: 10'h200};

  function automatic logic [WORD_W-1:0] cfg_to_word(input bank_cfg_t c);
    return {c.il4, c.single, c.fitted, 3'b000, c.lim};
  endfunction
endpackage

// File: rtl/tob_cfg_regs.sv
module tob_cfg_regs
  import tob_pkg::*;
#(
  parameter int NB    = 8,
  parameter int IDX_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         widx,
  input  logic [1:0]               be,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [IDX_W-1:0]         raddr,
  output logic [WORD_W-1:0]        rdata,
  output bank_cfg_t [NB-1:0]       cfg_o
);
  for (genvar i = 0; i < NB; i++) begin : g_bank
    bank_cfg_t cur_q;
    bank_cfg_t cur_d;
    logic      wr_en;

    assign wr_en = we && (widx == IDX_W'(i));

    always_comb begin
      cur_d = cur_q;
      if (be[0]) begin
        cur_d.lim[7:0] = wdata[7:0];
      end
      if (be[1]) begin
        cur_d.lim[LIM_W-1:8] = wdata[LIM_W-1:8];
        cur_d.fitted         = wdata[13];
        cur_d.single         = wdata[14];
        cur_d.il4            = wdata[15];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= CFG_RST;
      end else if (wr_en) begin
        cur_q <= cur_d;
      end
    end

    assign cfg_o[i] = cur_q;
  end

  assign rdata = cfg_to_word(cfg_o[raddr]);
endmodule

// File: rtl/tob_match.sv
module tob_match
  import tob_pkg::*;
#(
  parameter int NB        = 8,
  parameter int ADDR_W    = 36,
  parameter int UNIT_LOG2 = 25
) (
  input  logic [ADDR_W-1:0]  addr,
  input  bank_cfg_t [NB-1:0] cfg,
  output logic [NB-1:0]      sel_oh,
  output logic               row,
  output logic               mode4,
  output logic               miss
);
  localparam int UNIT_W = ADDR_W - UNIT_LOG2;
  localparam int HALF_W = UNIT_W + 1;
  localparam int CMP_W  = (UNIT_W > LIM_W) ? UNIT_W : LIM_W;
  localparam int MID_W  = ((HALF_W > LIM_W + 1) ? HALF_W : LIM_W + 1) + 1;

  logic [UNIT_W-1:0] a_unit;
  logic [HALF_W-1:0] a_half;
  logic [NB-1:0]     hit;
  logic [NB-1:0]     row_vec;
  logic [NB-1:0]     il_vec;

  assign a_unit = addr[ADDR_W-1:UNIT_LOG2];
  assign a_half = addr[ADDR_W-1:UNIT_LOG2-1];

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    logic [LIM_W-1:0] lo;
    logic [MID_W-1:0] mid;
    if (i == 0) begin : g_first
      assign lo = '0;
    end else begin : g_rest
      assign lo = cfg[i-1].lim;
    end
    assign mid        = MID_W'(lo) + MID_W'(cfg[i].lim);
    assign hit[i]     = CMP_W'(cfg[i].lim) > CMP_W'(a_unit);
    assign row_vec[i] = !cfg[i].single && (MID_W'(a_half) >= mid);
    assign il_vec[i]  = cfg[i].il4;
  end

  assign sel_oh = hit & ~(hit - 1'b1);
  assign row    = |(sel_oh & row_vec);
  assign mode4  = |(sel_oh & il_vec);
  assign miss   = ~|hit;
endmodule

// File: rtl/tob_bank_decoder.sv
module tob_bank_decoder
  import tob_pkg::*;
#(
  parameter int NB        = 8,
  parameter int ADDR_W    = 36,
  parameter int UNIT_LOG2 = 25,
  parameter int IDX_W     = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_widx,
  input  logic [1:0]        cfg_be,
  input  logic [15:0]       cfg_wdata,
  input  logic [IDX_W-1:0]  cfg_raddr,
  output logic [15:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [NB-1:0]     bank_sel,
  output logic              row_sel,
  output logic              mode_4to1,
  output logic              miss,
  output logic [NB-1:0]     refresh_en
);
  bank_cfg_t [NB-1:0] cfg;
  logic [NB-1:0]      sel_d;
  logic               row_d;
  logic               mode_d;
  logic               miss_d;

  tob_cfg_regs #(.NB(NB), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .widx  (cfg_widx),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .raddr (cfg_raddr),
    .rdata (cfg_rdata),
    .cfg_o (cfg)
  );

  tob_match #(.NB(NB), .ADDR_W(ADDR_W), .UNIT_LOG2(UNIT_LOG2)) u_match (
    .addr   (addr_in),
    .cfg    (cfg),
    .sel_oh (sel_d),
    .row    (row_d),
    .mode4  (mode_d),
    .miss   (miss_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel  <= '0;
      row_sel   <= 1'b0;
      mode_4to1 <= 1'b0;
      miss      <= 1'b0;
    end else begin
      bank_sel  <= sel_d;
      row_sel   <= row_d;
      mode_4to1 <= mode_d;
      miss      <= miss_d;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_ref
    assign refresh_en[i] = cfg[i].fitted;
  end
endmodule

// File: rtl/tob_decoder_chk.sv
module tob_decoder_chk #(
  parameter int NB     = 8,
  parameter int ADDR_W = 36,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_raddr,
  input logic [15:0]       cfg_rdata,
  input logic [ADDR_W-1:0] addr_in,
  input logic [NB-1:0]     bank_sel,
  input logic              row_sel,
  input logic              mode_4to1,
  input logic              miss,
  input logic [NB-1:0]     refresh_en
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));

  // R5
  miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != '0) |-> !miss);

  // R5
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (bank_sel == '0 && !row_sel && !mode_4to1));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[12:10] == 3'b000);

  // R8
  refresh_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en[cfg_raddr] == cfg_rdata[13]);

  // R9
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $stable(addr_in) && !$past(cfg_we)) |=>
      ($stable(bank_sel) && $stable(row_sel) && $stable(mode_4to1) && $stable(miss)));
endmodule

bind tob_bank_decoder tob_decoder_chk #(.NB(NB), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_raddr  (cfg_raddr),
  .cfg_rdata  (cfg_rdata),
  .addr_in    (addr_in),
  .bank_sel   (bank_sel),
  .row_sel    (row_sel),
  .mode_4to1  (mode_4to1),
  .miss       (miss),
  .refresh_en (refresh_en)
);

// File: tb/test_tob_bank_decoder.sv
module test_tob_bank_decoder;
  localparam int NB = 8;
  localparam int AW = 36;
  localparam logic [AW-1:0] U = 36'd1 << 25;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_widx;
  logic [1:0]    cfg_be;
  logic [15:0]   cfg_wdata;
  logic [2:0]    cfg_raddr;
  logic [15:0]   cfg_rdata;
  logic [AW-1:0] addr_in;
  logic [NB-1:0] bank_sel;
  logic          row_sel;
  logic          mode_4to1;
  logic          miss;
  logic [NB-1:0] refresh_en;

  always #5 clk = ~clk;

  tob_bank_decoder i_tob_bank_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .addr_in(addr_in),
    .bank_sel(bank_sel), .row_sel(row_sel), .mode_4to1(mode_4to1), .miss(miss),
    .refresh_en(refresh_en)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [NB-1:0] sel;
    logic          row;
    logic          mode;
    logic          miss;
  } exp_t;

  exp_t        q[$];
  logic [15:0] mreg [NB];
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [AW-1:0] a);
    exp_t e;
    logic [10:0] au;
    logic [11:0] ah;
    logic [9:0]  lo;
    e.a = a; e.sel = '0; e.row = 0; e.mode = 0; e.miss = 1;
    au = a[AW-1:25];
    ah = a[AW-1:24];
    for (int i = 0; i < NB; i++) begin
      if (e.miss && ({1'b0, mreg[i][9:0]} > au)) begin
        e.miss = 0;
        e.sel  = NB'(1) << i;
        lo     = (i == 0) ? 10'd0 : mreg[i-1][9:0];
        e.mode = mreg[i][15];
        e.row  = !mreg[i][14] && (ah >= (12'(lo) + 12'(mreg[i][9:0])));
      end
    end
    return e;
  endfunction

  // R9: one result expected per posedge after the address is driven
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(bank_sel == e.sel, "R3 R4 R9 bank_sel", bank_sel, e.sel);
      check(miss == e.miss,    "R5 miss",           miss, e.miss);
      check(row_sel == e.row,  "R6 row_sel",        row_sel, e.row);
      check(mode_4to1 == e.mode, "R7 mode_4to1",    mode_4to1, e.mode);
    end
  end

  task automatic lookup(input logic [AW-1:0] a);
    @(negedge clk);
    addr_in = a;
    q.push_back(model(a));
  endtask

  task automatic wr(input int idx, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    cfg_we = 1'b1; cfg_widx = 3'(idx); cfg_wdata = d; cfg_be = be;
    if (be[0]) mreg[idx][7:0] = d[7:0];
    if (be[1]) begin
      mreg[idx][15:13] = d[15:13];
      mreg[idx][9:8]   = d[9:8];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input int idx, input string req);
    @(negedge clk);
    cfg_raddr = 3'(idx);
    #1;
    check(cfg_rdata == mreg[idx], req, cfg_rdata, mreg[idx]);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sweep();
    logic [9:0] lo;
    lookup('0);
    for (int b = 0; b < NB; b++) begin
      logic [AW-1:0] t;
      t  = AW'(mreg[b][9:0]) * U;
      lo = (b == 0) ? 10'd0 : mreg[b-1][9:0];
      lookup(t - 1);              // R4: last byte below each limit
      lookup(t);                  // R4: first byte at each limit
      if (t >= U) lookup(t - U);
      lookup(t + U);
      lookup((AW'(lo) + AW'(mreg[b][9:0])) * (U >> 1));       // R6 midpoint
      lookup((AW'(lo) + AW'(mreg[b][9:0])) * (U >> 1) - 1);
    end
    lookup({AW{1'b1}});           // R5 far above memory
    drain();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_widx = 0; cfg_be = 0; cfg_wdata = 0;
    cfg_raddr = 0; addr_in = '0;
    for (int i = 0; i < NB; i++) mreg[i] = 16'hA200;
    repeat (3) @(negedge clk);
    check(bank_sel == '0 && !miss, "R9 reset outputs", bank_sel, 0);
    rst_n = 1'b1;

    // R1 reset contents
    for (int i = 0; i < NB; i++) rd_check(i, "R1 reset word");
    check(refresh_en == 8'hFF, "R8 reset refresh", refresh_en, 8'hFF);
    sweep();

    // R2 byte enables and reserved bits
    wr(7, 16'hFFFF, 2'b11); rd_check(7, "R2 reserved masked");
    check(cfg_rdata == 16'hE3FF, "R2 all-ones readback", cfg_rdata, 16'hE3FF);
    wr(7, 16'h1C12, 2'b01); rd_check(7, "R2 low byte only");
    check(cfg_rdata == 16'hE312, "R2 low byte value", cfg_rdata, 16'hE312);
    wr(7, 16'h1C00, 2'b10); rd_check(7, "R2 high byte only");
    check(cfg_rdata == 16'h0012, "R2 high byte value", cfg_rdata, 16'h0012);
    check(refresh_en[7] == 1'b0, "R8 unfitted bank", refresh_en[7], 0);

    // layout with zero-size banks
    wr(0, 16'h2004, 2'b11);
    wr(1, 16'h0004, 2'b11);
    wr(2, 16'hE00C, 2'b11);
    wr(3, 16'hA010, 2'b11);
    wr(4, 16'h0010, 2'b11);
    wr(5, 16'h2020, 2'b11);
    wr(6, 16'h6028, 2'b11);
    wr(7, 16'h0028, 2'b11);
    for (int i = 0; i < NB; i++) rd_check(i, "R1 programmed word");
    check(refresh_en == 8'h6D, "R8 refresh vector", refresh_en, 8'h6D);
    sweep();

    // R3 priority with an overlapping lower limit
    wr(3, 16'hA002, 2'b11);
    sweep();
    wr(0, 16'h0000, 2'b11);
    wr(1, 16'h0000, 2'b11);
    sweep();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule